// File: doc/BRIEF.md
# Translation and Protection Fault Arbiter

This block takes the result of a virtual-to-physical translation and the physical memory protection verdicts for the same access, and turns them into one outcome: a grant, a page fault or an access fault. A fault comes with its exception cause code and the faulting virtual address. A translation failure always wins over a protection failure. Protection is only consulted once translation has succeeded. A protection failure, whether on the final address or on a page-table-entry read during the walk, always reports as an access fault.

The block also works out the privilege level that the protection matcher must use for the final-address check, along with the permission the access needs. Page-table-entry reads are checked as loads at supervisor level. Their verdicts arrive on a separate strobe during the walk and are remembered until the access completes. The page-table walker and the region matcher sit outside this block. The outcome appears one clock after the access is presented.

Top module: `xlat_fault_arbiter`

## Requirements
- R1: While reset is held, and in any cycle with no outcome, `out_valid`, `grant`, `page_fault`, `access_fault` and `fault_valid` are low, and `fault_cause` and `fault_tval` are zero.
- R2: An access presented with `acc_valid` produces exactly one of `grant`, `page_fault` or `access_fault`, together with `out_valid`, on the next clock. `grant` is given when the translation status is success (code 0), the final protection verdict passes, and no page-table-entry read failed.
- R3: A translation status of fail (code 1, and also the unused code 3) gives a page fault in paged mode, even when the final protection verdict also fails.
- R4: After a successful translation, a failed final protection verdict gives an access fault, even in paged mode.
- R5: A failed protection verdict on any page-table-entry read (`pte_rd_valid` high with `pte_rd_pmp_ok` low) since the previous access gives an access fault for the next access. This holds whatever translation status that access reports, including when the failing read arrives in the same cycle as the access.
- R6: A translation status of protection fail (code 2) gives an access fault.
- R7: Cause codes are 1/5/7 (access fault) and 12/13/15 (page fault) for fetch/load/store. Here `acc_type` is 0 for fetch, 1 for load, 2 for store, and 3 is treated as a load. Page-fault codes are used only when `spec_ge_110` is high, `satp_bare` is low, and the failure is not a protection failure; every other fault uses the access-fault code.
- R8: `eff_priv` equals `mpp` for loads and stores when `cur_priv` is machine (3) and `mprv` is set. In every other case, and always for fetches, it equals `cur_priv`. Privilege encodings are 0 user, 1 supervisor, 3 machine.
- R9: `req_perm` is one-hot with bit 0 read, bit 1 write and bit 2 execute. It is 3'b100 for a fetch, 3'b010 for a store and 3'b001 for a load.
- R10: On a fault, `fault_valid` is high in the outcome cycle, with `fault_cause` and `fault_tval` (the access's `acc_vaddr`). On a grant, `fault_valid` is low and both values are zero.
- R11: With parameter `PMP_EN` at 0, the final verdict and the page-table-entry verdicts are treated as passes. A protection-fail status code from the walker is still honoured.
- R12: The memory of a failed page-table-entry read is cleared by the access it applies to, so the following access is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access result presented this cycle |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store |
| acc_vaddr | input | VA_W | Virtual address of the access |
| cur_priv | input | 2 | Current privilege level |
| mprv | input | 1 | Modify-privilege status bit |
| mpp | input | 2 | Previous-privilege status field |
| spec_ge_110 | input | 1 | Privilege specification 1.10 or later |
| satp_bare | input | 1 | Address translation mode is bare |
| xlat_status | input | 2 | 0 success, 1 fail, 2 protection fail |
| final_pmp_ok | input | 1 | Protection verdict for the final physical address |
| pte_rd_valid | input | 1 | A page-table-entry read was checked this cycle |
| pte_rd_pmp_ok | input | 1 | Protection verdict for that read |
| eff_priv | output | 2 | Effective privilege for the final protection check |
| req_perm | output | 3 | Permission the access needs (X,W,R) |
| out_valid | output | 1 | Outcome valid |
| grant | output | 1 | Access granted |
| page_fault | output | 1 | Outcome is a page fault |
| access_fault | output | 1 | Outcome is an access fault |
| fault_valid | output | 1 | Fault strobe |
| fault_cause | output | 5 | Exception cause code |
| fault_tval | output | VA_W | Faulting virtual address |

## Verification
A wrong remembered page-table-entry failure shows at the ports on the next access. That access gives an access fault where a grant or page fault was expected, or the reverse, so the error is visible one clock after that access is presented. A wrong priority between the translation and protection results shows as the wrong fault class and cause code in the outcome cycle. The effective privilege is combinational, so a wrong choice shows in the same cycle the inputs change. Running a protection-disabled copy alongside the default one exposes any verdict that leaks through the parameter.

// File: rtl/xfa_pkg.sv
package xfa_pkg;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_FAIL = 2'd1, ST_PROT = 2'd2, ST_UNUSED = 2'd3} xst_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] C_FETCH_ACC = 5'd1;
  localparam logic [CAUSE_W-1:0] C_LOAD_ACC  = 5'd5;
  localparam logic [CAUSE_W-1:0] C_STORE_ACC = 5'd7;
  localparam logic [CAUSE_W-1:0] C_FETCH_PG  = 5'd12;
  localparam logic [CAUSE_W-1:0] C_LOAD_PG   = 5'd13;
  localparam logic [CAUSE_W-1:0] C_STORE_PG  = 5'd15;

  // Cause selection for a fault of a given access kind.
  function automatic logic [CAUSE_W-1:0] cause_code(input logic [1:0] kind, input logic use_page);
    logic [CAUSE_W-1:0] c;
    unique case (kind)
      2'(ACC_FETCH): c = use_page ? C_FETCH_PG : C_FETCH_ACC;
      2'(ACC_STORE): c = use_page ? C_STORE_PG : C_STORE_ACC;
      default:       c = use_page ? C_LOAD_PG  : C_LOAD_ACC;
    endcase
    return c;
  endfunction

  // Permission mask {X,W,R} needed by an access kind.
  function automatic logic [2:0] perm_of(input logic [1:0] kind);
    logic [2:0] p;
    unique case (kind)
      2'(ACC_FETCH): p = 3'b100;
      2'(ACC_STORE): p = 3'b010;
      default:       p = 3'b001;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/xfa_priv_sel.sv
module xfa_priv_sel
  import xfa_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic [1:0] cur_priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  output logic [1:0] eff_priv,
  output logic [2:0] req_perm
);
  logic is_fetch;
  logic borrow;

  assign is_fetch = (acc_type == 2'(ACC_FETCH));
  assign borrow   = (cur_priv == PRIV_M) && mprv && !is_fetch;

  always_comb begin
    eff_priv = borrow ? mpp : cur_priv;
    req_perm = perm_of(acc_type);
  end
endmodule

// File: rtl/xfa_walk_track.sv
module xfa_walk_track #(
  parameter bit PMP_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pte_rd_valid,
  input  logic pte_rd_pmp_ok,
  input  logic acc_valid,
  output logic pte_fail_seen
);
  if (PMP_EN) begin : g_track
    logic sticky_q;
    logic fail_now;

    assign fail_now      = pte_rd_valid && !pte_rd_pmp_ok;
    assign pte_fail_seen = sticky_q || fail_now;

    always_ff @(posedge clk) begin
      if (!rst_n)         sticky_q <= 1'b0;
      else if (acc_valid) sticky_q <= 1'b0;
      else                sticky_q <= pte_fail_seen;
    end
  end else begin : g_off
    logic unused_in;
    assign unused_in     = ^{clk, rst_n, pte_rd_valid, pte_rd_pmp_ok, acc_valid};
    assign pte_fail_seen = 1'b0;
  end
endmodule

// File: rtl/xfa_outcome.sv
module xfa_outcome
  import xfa_pkg::*;
(
  input  logic [1:0]         acc_type,
  input  logic               prot_fail,
  input  logic               xlat_ok,
  input  logic               spec_ge_110,
  input  logic               satp_bare,
  output logic               grant,
  output logic               page_fault,
  output logic               access_fault,
  output logic [CAUSE_W-1:0] cause
);
  logic paged;

  assign paged = spec_ge_110 && !satp_bare && !prot_fail;

  always_comb begin
    grant        = xlat_ok && !prot_fail;
    page_fault   = !grant && paged;
    access_fault = !grant && !paged;
    cause        = grant ? '0 : cause_code(acc_type, paged);
  end
endmodule

// File: rtl/xlat_fault_arbiter.sv
module xlat_fault_arbiter
  import xfa_pkg::*;
#(
  parameter int VA_W   = 39,
  parameter bit PMP_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [1:0]         acc_type,
  input  logic [VA_W-1:0]    acc_vaddr,
  input  logic [1:0]         cur_priv,
  input  logic               mprv,
  input  logic [1:0]         mpp,
  input  logic               spec_ge_110,
  input  logic               satp_bare,
  input  logic [1:0]         xlat_status,
  input  logic               final_pmp_ok,
  input  logic               pte_rd_valid,
  input  logic               pte_rd_pmp_ok,
  output logic [1:0]         eff_priv,
  output logic [2:0]         req_perm,
  output logic               out_valid,
  output logic               grant,
  output logic               page_fault,
  output logic               access_fault,
  output logic               fault_valid,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic [VA_W-1:0]    fault_tval
);
  // Named internal events, also used by the checker.
  logic               pte_fail_seen;
  logic               st_ok;
  logic               st_prot;
  logic               final_fail;
  logic               prot_fail;
  logic               xlat_ok;
  logic               nx_grant;
  logic               nx_pf;
  logic               nx_af;
  logic [CAUSE_W-1:0] nx_cause;

  xfa_priv_sel u_priv (
    .acc_type (acc_type),
    .cur_priv (cur_priv),
    .mprv     (mprv),
    .mpp      (mpp),
    .eff_priv (eff_priv),
    .req_perm (req_perm)
  );

  xfa_walk_track #(.PMP_EN(PMP_EN)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pte_rd_valid  (pte_rd_valid),
    .pte_rd_pmp_ok (pte_rd_pmp_ok),
    .acc_valid     (acc_valid),
    .pte_fail_seen (pte_fail_seen)
  );

  assign st_ok      = (xlat_status == 2'(ST_OK));
  assign st_prot    = (xlat_status == 2'(ST_PROT));
  // The final-address verdict only counts after a good translation.
  assign final_fail = PMP_EN && st_ok && !final_pmp_ok;
  assign prot_fail  = pte_fail_seen || st_prot || final_fail;
  assign xlat_ok    = st_ok;

  xfa_outcome u_out (
    .acc_type     (acc_type),
    .prot_fail    (prot_fail),
    .xlat_ok      (xlat_ok),
    .spec_ge_110  (spec_ge_110),
    .satp_bare    (satp_bare),
    .grant        (nx_grant),
    .page_fault   (nx_pf),
    .access_fault (nx_af),
    .cause        (nx_cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !acc_valid) begin
      out_valid    <= 1'b0;
      grant        <= 1'b0;
      page_fault   <= 1'b0;
      access_fault <= 1'b0;
      fault_valid  <= 1'b0;
      fault_cause  <= '0;
      fault_tval   <= '0;
    end else begin
      out_valid    <= 1'b1;
      grant        <= nx_grant;
      page_fault   <= nx_pf;
      access_fault <= nx_af;
      fault_valid  <= !nx_grant;
      fault_cause  <= nx_cause;
      fault_tval   <= nx_grant ? '0 : acc_vaddr;
    end
  end
endmodule

// File: rtl/xfa_checker.sv
module xfa_checker
  import xfa_pkg::*;
#(
  parameter int VA_W = 39
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [1:0]      acc_type,
  input logic [VA_W-1:0] acc_vaddr,
  input logic [1:0]      cur_priv,
  input logic            spec_ge_110,
  input logic            satp_bare,
  input logic [1:0]      eff_priv,
  input logic            out_valid,
  input logic            grant,
  input logic            page_fault,
  input logic            access_fault,
  input logic            fault_valid,
  input logic [VA_W-1:0] fault_tval,
  input logic            pte_fail_seen
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !grant && !page_fault && !access_fault && !fault_valid); // R1

  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> out_valid); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({grant, page_fault, access_fault}) == 1); // R2

  AST_PTE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && pte_fail_seen |=> access_fault); // R5

  AST_PAGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> $past(spec_ge_110) && !$past(satp_bare)); // R7

  AST_FETCH_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == 2'(ACC_FETCH) |-> eff_priv == cur_priv); // R8

  AST_FAULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !grant |-> fault_valid); // R10

  AST_TVAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> fault_tval == $past(acc_vaddr)); // R10
endmodule

bind xlat_fault_arbiter xfa_checker #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_type      (acc_type),
  .acc_vaddr     (acc_vaddr),
  .cur_priv      (cur_priv),
  .spec_ge_110   (spec_ge_110),
  .satp_bare     (satp_bare),
  .eff_priv      (eff_priv),
  .out_valid     (out_valid),
  .grant         (grant),
  .page_fault    (page_fault),
  .access_fault  (access_fault),
  .fault_valid   (fault_valid),
  .fault_tval    (fault_tval),
  .pte_fail_seen (pte_fail_seen)
);

// File: tb/xlat_fault_arbiter_test.sv
module xlat_fault_arbiter_test;
  localparam int VA = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_type = 2'd0;
  logic [VA-1:0] acc_vaddr = '0;
  logic [1:0]    cur_priv = 2'd3;
  logic          mprv = 1'b0;
  logic [1:0]    mpp = 2'd0;
  logic          spec_ge_110 = 1'b1;
  logic          satp_bare = 1'b0;
  logic [1:0]    xlat_status = 2'd0;
  logic          final_pmp_ok = 1'b1;
  logic          pte_rd_valid = 1'b0;
  logic          pte_rd_pmp_ok = 1'b1;

  logic [1:0]    eff_priv, eff_priv_o;
  logic [2:0]    req_perm, req_perm_o;
  logic          out_valid, grant, page_fault, access_fault, fault_valid;
  logic          out_valid_o, grant_o, page_fault_o, access_fault_o, fault_valid_o;
  logic [4:0]    fault_cause, fault_cause_o;
  logic [VA-1:0] fault_tval, fault_tval_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xlat_fault_arbiter #(.VA_W(VA), .PMP_EN(1'b1)) uut (
    .clk, .rst_n, .acc_valid, .acc_type, .acc_vaddr, .cur_priv, .mprv, .mpp,
    .spec_ge_110, .satp_bare, .xlat_status, .final_pmp_ok, .pte_rd_valid, .pte_rd_pmp_ok,
    .eff_priv, .req_perm, .out_valid, .grant, .page_fault, .access_fault,
    .fault_valid, .fault_cause, .fault_tval
  );

  xlat_fault_arbiter #(.VA_W(VA), .PMP_EN(1'b0)) uut_off (
    .clk, .rst_n, .acc_valid, .acc_type, .acc_vaddr, .cur_priv, .mprv, .mpp,
    .spec_ge_110, .satp_bare, .xlat_status, .final_pmp_ok, .pte_rd_valid, .pte_rd_pmp_ok,
    .eff_priv(eff_priv_o), .req_perm(req_perm_o), .out_valid(out_valid_o), .grant(grant_o),
    .page_fault(page_fault_o), .access_fault(access_fault_o), .fault_valid(fault_valid_o),
    .fault_cause(fault_cause_o), .fault_tval(fault_tval_o)
  );

  typedef struct {
    bit          g;
    bit          pf;
    bit          af;
    logic [4:0]  cause;
    logic [VA-1:0] tval;
  } res_t;

  typedef struct {
    string tag;
    res_t  on;
    res_t  off;
  } item_t;

  item_t sb[$];

  // Reference outcome written from the requirements.
  function automatic res_t predict(bit pmp, logic [1:0] t, logic spec, logic bare,
                                   logic [1:0] st, logic fin_ok, logic pte_bad, logic [VA-1:0] va);
    res_t r;
    bit prot;
    bit use_pg;
    prot = (pmp && pte_bad) || (st == 2'd2) || (st == 2'd0 && pmp && !fin_ok);
    r.g  = (st == 2'd0) && !prot;
    use_pg = !r.g && !prot && spec && !bare;
    r.pf = use_pg;
    r.af = !r.g && !use_pg;
    if (r.g) r.cause = 5'd0;
    else if (t == 2'd0) r.cause = use_pg ? 5'd12 : 5'd1;
    else if (t == 2'd2) r.cause = use_pg ? 5'd15 : 5'd7;
    else r.cause = use_pg ? 5'd13 : 5'd5;
    r.tval = r.g ? '0 : va;
    return r;
  endfunction

  task automatic chk(input string tag, input bit ok, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Driver: optional failing table-entry read, then the access itself.
  task automatic access(input string tag, input logic [1:0] t, input logic [1:0] st,
                        input logic fin_ok, input logic pte_bad, input logic [VA-1:0] va,
                        input logic spec = 1'b1, input logic bare = 1'b0);
    item_t it;
    @(posedge clk); #1;
    if (pte_bad) begin
      pte_rd_valid = 1'b1; pte_rd_pmp_ok = 1'b0;
      @(posedge clk); #1;
      pte_rd_valid = 1'b0; pte_rd_pmp_ok = 1'b1;
    end
    acc_type = t; xlat_status = st; final_pmp_ok = fin_ok; acc_vaddr = va;
    spec_ge_110 = spec; satp_bare = bare; acc_valid = 1'b1;
    it.tag = tag;
    it.on  = predict(1'b1, t, spec, bare, st, fin_ok, pte_bad, va);
    it.off = predict(1'b0, t, spec, bare, st, fin_ok, pte_bad, va);
    sb.push_back(it);
    @(posedge clk); #1;
    acc_valid = 1'b0; final_pmp_ok = 1'b1; xlat_status = 2'd0;
  endtask

  // Monitor: compares each outcome against the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sb.size() == 0) begin
        chk("R2 unexpected outcome", 1'b0, "valid", "idle");
      end else begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " class"},
            grant == it.on.g && page_fault == it.on.pf && access_fault == it.on.af,
            $sformatf("g%0d pf%0d af%0d", grant, page_fault, access_fault),
            $sformatf("g%0d pf%0d af%0d", it.on.g, it.on.pf, it.on.af));
        chk({it.tag, " R10 cause/tval"},
            fault_cause == it.on.cause && fault_tval == it.on.tval && fault_valid == !it.on.g,
            $sformatf("c%0d v%0h f%0d", fault_cause, fault_tval, fault_valid),
            $sformatf("c%0d v%0h f%0d", it.on.cause, it.on.tval, !it.on.g));
        chk({it.tag, " R11 pmp-off copy"},
            out_valid_o && grant_o == it.off.g && page_fault_o == it.off.pf &&
            access_fault_o == it.off.af && fault_cause_o == it.off.cause,
            $sformatf("g%0d pf%0d af%0d c%0d", grant_o, page_fault_o, access_fault_o, fault_cause_o),
            $sformatf("g%0d pf%0d af%0d c%0d", it.off.g, it.off.pf, it.off.af, it.off.cause));
      end
    end
  end

  task automatic priv_case(input string tag, input logic [1:0] t, input logic [1:0] p,
                           input logic m, input logic [1:0] pp, input logic [1:0] exp_p,
                           input logic [2:0] exp_perm);
    @(negedge clk);
    acc_type = t; cur_priv = p; mprv = m; mpp = pp;
    #1;
    chk({tag, " R8 eff_priv"}, eff_priv == exp_p, $sformatf("%0d", eff_priv), $sformatf("%0d", exp_p));
    chk({tag, " R9 req_perm"}, req_perm == exp_perm, $sformatf("%b", req_perm), $sformatf("%b", exp_perm));
  endtask

  initial begin : watchdog
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", !out_valid && !fault_valid && !grant && fault_cause == 0,
        $sformatf("v%0d f%0d", out_valid, fault_valid), "v0 f0");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", !out_valid && !fault_valid && fault_tval == 0,
        $sformatf("v%0d f%0d", out_valid, fault_valid), "v0 f0");

    access("R2 load ok",    2'd1, 2'd0, 1'b1, 1'b0, 39'h10_0000);
    access("R2 store ok",   2'd2, 2'd0, 1'b1, 1'b0, 39'h10_0008);
    access("R2 fetch ok",   2'd0, 2'd0, 1'b1, 1'b0, 39'h10_0010);
    access("R3 fetch pf",   2'd0, 2'd1, 1'b0, 1'b0, 39'h7f_1234_5000);
    access("R3 load pf",    2'd1, 2'd1, 1'b0, 1'b0, 39'h7f_1234_5008);
    access("R3 store pf",   2'd2, 2'd3, 1'b0, 1'b0, 39'h7f_1234_5010);
    access("R4 load af",    2'd1, 2'd0, 1'b0, 1'b0, 39'h00_2000_0040);
    access("R4 fetch af",   2'd0, 2'd0, 1'b0, 1'b0, 39'h00_2000_0044);
    access("R4 store af",   2'd2, 2'd0, 1'b0, 1'b0, 39'h00_2000_0048);
    access("R5 pte bad+fail", 2'd1, 2'd1, 1'b1, 1'b1, 39'h55_0000_1000);
    access("R12 next clean",  2'd1, 2'd0, 1'b1, 1'b0, 39'h55_0000_2000);
    access("R5 pte bad+ok",   2'd2, 2'd0, 1'b1, 1'b1, 39'h55_0000_3000);
    access("R12 after store", 2'd2, 2'd1, 1'b1, 1'b0, 39'h55_0000_4000);
    access("R6 prot status",  2'd2, 2'd2, 1'b1, 1'b0, 39'h66_0000_0000);
    access("R7 bare fail",    2'd1, 2'd1, 1'b1, 1'b0, 39'h00_0000_0abc, 1'b1, 1'b1);
    access("R7 old spec",     2'd0, 2'd1, 1'b1, 1'b0, 39'h00_0000_0def, 1'b0, 1'b0);
    access("R7 old spec st",  2'd2, 2'd1, 1'b1, 1'b0, 39'h00_0000_0f00, 1'b0, 1'b0);

    // Failing table-entry read in the same cycle as the access.
    @(posedge clk); #1;
    acc_type = 2'd1; xlat_status = 2'd0; final_pmp_ok = 1'b1; acc_vaddr = 39'h12_3456;
    spec_ge_110 = 1'b1; satp_bare = 1'b0; acc_valid = 1'b1;
    pte_rd_valid = 1'b1; pte_rd_pmp_ok = 1'b0;
    begin
      item_t it;
      it.tag = "R5 same-cycle pte";
      it.on  = predict(1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 39'h12_3456);
      it.off = predict(1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 39'h12_3456);
      sb.push_back(it);
    end
    @(posedge clk); #1;
    acc_valid = 1'b0; pte_rd_valid = 1'b0; pte_rd_pmp_ok = 1'b1;
    access("R12 after same-cycle", 2'd1, 2'd0, 1'b1, 1'b0, 39'h12_3460);

    repeat (3) @(posedge clk);
    priv_case("M mprv load",  2'd1, 2'd3, 1'b1, 2'd1, 2'd1, 3'b001);
    priv_case("M mprv store", 2'd2, 2'd3, 1'b1, 2'd0, 2'd0, 3'b010);
    priv_case("M mprv fetch", 2'd0, 2'd3, 1'b1, 2'd1, 2'd3, 3'b100);
    priv_case("M plain load", 2'd1, 2'd3, 1'b0, 2'd1, 2'd3, 3'b001);
    priv_case("S mprv load",  2'd1, 2'd1, 1'b1, 2'd0, 2'd1, 3'b001);
    priv_case("U rsvd type",  2'd3, 2'd0, 1'b1, 2'd3, 2'd0, 3'b001);

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 all outcomes seen", sb.size() == 0, $sformatf("%0d left", sb.size()), "0 left");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule